// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a 32,768 Hz enable strobe into a one-clock pulse once per second and a 512 Hz square wave for frequency measurement. It also applies a signed digital trim to the seconds path. A 64-minute trim cycle runs inside the block. In the opening second of each selected minute, the block either holds the fine divider stage for 128 strobes, which makes that second longer, or advances the coarse stage by one step, which makes that second 256 strobes shorter. The square-wave path has a counter of its own and never sees the trim.

The surrounding logic supplies the strobe, a run gate, a divider clear and the trim code (a direction bit and a five-bit magnitude). It receives the seconds pulse. The minute position within the trim cycle is brought out so that a bench can line up the trim slots with the pulse train.

Top module: `cal_prescaler`

## Requirements
- R1: With no trim in effect, `sec_tick` is high for exactly one clock cycle after every 2^(LOW_W+UP_W) accepted strobes (32,768 by default). A strobe is accepted when `osc_tick` and `osc_run` are both high.
- R2: `sq512` toggles after every 2^SQ_W accepted strobes (32 by default). This spacing holds whatever the trim code is, and also during blanked or shortened seconds.
- R3: Each `sec_tick` advances a seconds-in-minute count of SEC_PER_MIN positions. `minute_idx` advances by one when that count wraps and returns to 0 after 63. It changes only in the cycle that `sec_tick` is high.
- R4: A trim slot is the first second of minute m, for every m lower than twice the value of `trim_mag`. Minutes 62 and 63 are never trimmed.
- R5: In a trim slot with `trim_pos` = 0, the second lasts 128 accepted strobes longer than nominal.
- R6: In a trim slot with `trim_pos` = 1, the second lasts 256 accepted strobes shorter than nominal.
- R7: When `trim_mag` is 0, every second has the nominal length, whatever the value of `trim_pos`.
- R8: While `osc_run` is low, no `sec_tick` occurs, and `sq512` and `minute_idx` hold their values. Strobes that arrive during this time are not counted.
- R9: A `div_clr` pulse clears both divider stages and the square-wave counter, drives `sq512` low and leaves `minute_idx` unchanged. Outside a trim slot, the next `sec_tick` follows exactly one nominal second of accepted strobes after the clear.
- R10: After reset, `sec_tick`, `sq512` and `minute_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | One-cycle strobe at the oscillator rate |
| osc_run | input | 1 | Oscillator running; when low, the block freezes |
| div_clr | input | 1 | Pulse that restarts the divider chain |
| trim_pos | input | 1 | Trim direction: 1 speeds the clock up, 0 slows it down |
| trim_mag | input | MAG_W | Trim magnitude; each step adds two trimmed minutes |
| sec_tick | output | 1 | One-cycle pulse once per second |
| sq512 | output | 1 | Test square wave at 1/64 of the strobe rate |
| minute_idx | output | MAG_W+1 | Minute position inside the 64-minute trim cycle |

## Verification
The hardest case to reach is the edge of the trim window. The bench must show that minute 61 is still trimmed, that minutes 62 and 63 are not, and that the pattern starts again once the minute index wraps. With the default divider, that takes more than an hour of strobes. The bench therefore shortens the coarse stage to one bit and the minute to two seconds, keeps the fine stage at eight bits so that the blank and insert sizes stay true, and runs a full trim cycle at the largest magnitude. A model in the bench predicts the length of each second and the minute index that goes with it.

// File: rtl/cal_prescaler_pkg.sv
package cal_prescaler_pkg;
    localparam int FINE_W_DEF     = 8;   // divide-by-256 stage
    localparam int COARSE_W_DEF   = 7;   // 128 fine carries per second
    localparam int SQ_W_DEF       = 5;   // half period of the test wave
    localparam int SEC_PER_MIN_DEF = 60;
    localparam int MAG_W_DEF      = 5;
endpackage

// File: rtl/cp_square.sv
module cp_square #(
    parameter int HALF_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic sq
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              wave;
    } sq_st_t;

    sq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.wave = 1'b0;
        end else if (en) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (&st_q.cnt) st_d.wave = ~st_q.wave;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sq = st_q.wave;

    AST_SQ_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !sq); // R9
    AST_SQ_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(sq)); // R8
endmodule

// File: rtl/cp_divider.sv
module cp_divider #(
    parameter int FINE_W   = 8,
    parameter int COARSE_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic slot_ok,
    input  logic trim_pos,
    output logic carry
);
    localparam int BLK_W = FINE_W - 1;   // blank length is half the fine stage

    typedef struct packed {
        logic [FINE_W-1:0]   fine;
        logic [COARSE_W-1:0] coarse;
        logic [BLK_W-1:0]    blk;
        logic                done;
    } dv_st_t;

    dv_st_t st_d, st_q;
    logic   want, blanking, ins, fine_max, coarse_max;

    always_comb begin
        want       = slot_ok && !st_q.done;
        blanking   = en && want && !trim_pos;
        ins        = en && want && trim_pos;
        fine_max   = &st_q.fine;
        coarse_max = &st_q.coarse;
        carry      = en && !clr && !blanking && fine_max && coarse_max;

        st_d = st_q;
        if (clr) begin
            st_d.fine   = '0;
            st_d.coarse = '0;
            st_d.blk    = '0;
        end else if (blanking) begin
            st_d.blk = st_q.blk + 1'b1;
            if (&st_q.blk) st_d.done = 1'b1;
        end else if (en) begin
            st_d.fine   = st_q.fine + 1'b1;
            st_d.coarse = st_q.coarse + COARSE_W'(fine_max) + COARSE_W'(ins);
            if (carry)    st_d.done = 1'b0;
            else if (ins) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_BLANK_HOLDS_FINE: assert property (@(posedge clk) disable iff (!rst_n)
        (blanking && !clr) |=> $stable(st_q.fine)); // R5
    AST_INSERT_STEPS_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && !clr) |=> (st_q.coarse != $past(st_q.coarse))); // R6
    AST_CLR_EMPTIES_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.fine == '0 && st_q.coarse == '0)); // R9
endmodule

// File: rtl/cp_slot.sv
module cp_slot #(
    parameter int SEC_PER_MIN = 60,
    parameter int MAG_W       = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               carry,
    input  logic [MAG_W-1:0]   mag,
    output logic               slot_ok,
    output logic               tick,
    output logic [MAG_W:0]     minute
);
    localparam int SEC_W = $clog2(SEC_PER_MIN + 1);
    localparam int MIN_W = MAG_W + 1;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic             pulse;
    } sl_st_t;

    sl_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = carry;
        if (carry) begin
            if (st_q.sec == SEC_W'(SEC_PER_MIN - 1)) begin
                st_d.sec = '0;
                st_d.min = st_q.min + 1'b1;
            end else begin
                st_d.sec = st_q.sec + 1'b1;
            end
        end
        slot_ok = (st_q.sec == '0) && (st_q.min < {mag, 1'b0});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick   = st_q.pulse;
    assign minute = st_q.min;

    AST_MINUTE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (minute != $past(minute)) |-> tick); // R3
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    AST_LAST_MINUTES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (minute >= MIN_W'(2 * ((1 << MAG_W) - 1))) |-> !slot_ok); // R4
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
    import cal_prescaler_pkg::*;
#(
    parameter int FINE_W      = FINE_W_DEF,
    parameter int COARSE_W    = COARSE_W_DEF,
    parameter int SQ_W        = SQ_W_DEF,
    parameter int SEC_PER_MIN = SEC_PER_MIN_DEF,
    parameter int MAG_W       = MAG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             osc_run,
    input  logic             div_clr,
    input  logic             trim_pos,
    input  logic [MAG_W-1:0] trim_mag,
    output logic             sec_tick,
    output logic             sq512,
    output logic [MAG_W:0]   minute_idx
);
    logic en, carry, slot_ok;

    assign en = osc_tick && osc_run;

    cp_square #(.HALF_W(SQ_W)) u_square (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .clr   (div_clr),
        .sq    (sq512)
    );

    cp_divider #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .clr      (div_clr),
        .slot_ok  (slot_ok),
        .trim_pos (trim_pos),
        .carry    (carry)
    );

    cp_slot #(.SEC_PER_MIN(SEC_PER_MIN), .MAG_W(MAG_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .carry   (carry),
        .mag     (trim_mag),
        .slot_ok (slot_ok),
        .tick    (sec_tick),
        .minute  (minute_idx)
    );

    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_run && !div_clr) |=> (!sec_tick && $stable(sq512) && $stable(minute_idx))); // R8
    AST_CLR_KEEPS_MINUTE: assert property (@(posedge clk) disable iff (!rst_n)
        div_clr |=> $stable(minute_idx)); // R9
endmodule

// File: tb/tb_cal_prescaler.sv
module tb_cal_prescaler;
    localparam int FINE_W  = 8;
    localparam int COARSE_W = 1;
    localparam int SQ_W    = 5;
    localparam int SPM     = 2;
    localparam int MAG_W   = 5;
    localparam int SEC_LEN = 1 << (FINE_W + COARSE_W);
    localparam int SQ_HALF = 1 << SQ_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic osc_run = 1'b1;
    logic div_clr = 1'b0;
    logic trim_pos = 1'b0;
    logic [MAG_W-1:0] trim_mag = '0;
    logic sec_tick, sq512;
    logic [MAG_W:0] minute_idx;

    always #2 clk = ~clk;

    cal_prescaler #(.FINE_W(FINE_W), .COARSE_W(COARSE_W), .SQ_W(SQ_W),
                    .SEC_PER_MIN(SPM), .MAG_W(MAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_run(osc_run),
        .div_clr(div_clr), .trim_pos(trim_pos), .trim_mag(trim_mag),
        .sec_tick(sec_tick), .sq512(sq512), .minute_idx(minute_idx));

    typedef struct { int len; int minute; string req; } exp_t;
    exp_t q[$];

    int n_checks = 0;
    int n_fail = 0;
    int s_model = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    int tick_cnt = 0;
    int sq_cnt = 0;
    logic sq_last = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Scoreboard monitor: measures each second and each square half period.
    always @(negedge clk) begin
        if (!rst_n || !mon_on) begin
            tick_cnt = 0;
            sq_cnt   = 0;
            sq_last  = sq512;
        end else begin
            if (sec_tick) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R1 unexpected tick", tick_cnt, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(tick_cnt == e.len, e.req, tick_cnt, e.len);
                    chk(int'(minute_idx) == e.minute, "R3 minute index", int'(minute_idx), e.minute);
                end
                tick_cnt = 0;
            end
            if (sq512 != sq_last) begin
                chk(sq_cnt == SQ_HALF, "R2 square half period", sq_cnt, SQ_HALF);
                sq_cnt  = 0;
                sq_last = sq512;
            end
            if (osc_tick && osc_run) begin
                tick_cnt++;
                sq_cnt++;
            end
        end
    end

    task automatic do_reset(input int mag, input bit pos);
        mon_on   = 1'b0;
        rst_n    = 1'b0;
        osc_tick = 1'b0;
        osc_run  = 1'b1;
        trim_mag = MAG_W'(mag);
        trim_pos = pos;
        s_model  = 0;
        q.delete();
        repeat (3) @(negedge clk);
        chk(sec_tick == 1'b0 && sq512 == 1'b0 && minute_idx == '0, "R10 reset state",
            int'({sec_tick, sq512, minute_idx}), 0);
        rst_n    = 1'b1;
        mon_on   = 1'b1;
        osc_tick = 1'b1;
    endtask

    // Driver: predicts each second from the requirements.
    task automatic push_secs(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int sec_in = s_model % SPM;
            int mnt    = (s_model / SPM) % 64;
            bit slot   = (sec_in == 0) && (mnt < 2 * int'(trim_mag));
            e.len = SEC_LEN;
            e.req = (trim_mag == 0) ? "R7 untrimmed length" : "R1 nominal length";
            if (slot && trim_pos) begin
                e.len = SEC_LEN - 256;
                e.req = "R6 R4 shortened slot";
            end else if (slot) begin
                e.len = SEC_LEN + 128;
                e.req = "R5 R4 stretched slot";
            end
            s_model++;
            e.minute = (s_model / SPM) % 64;
            q.push_back(e);
        end
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        // negative trim, magnitude 1: minutes 0 and 1 stretched
        do_reset(1, 1'b0);
        push_secs(8);
        drain();

        // positive trim, magnitude 3: minutes 0..5 shortened
        do_reset(3, 1'b1);
        push_secs(14);
        drain();

        // zero magnitude with positive sign, plus a freeze window
        do_reset(0, 1'b1);
        push_secs(4);
        repeat (200) @(negedge clk);
        begin
            logic sq_hold;
            logic [MAG_W:0] min_hold;
            bit frozen_ok = 1'b1;
            osc_run  = 1'b0;
            @(negedge clk);
            sq_hold  = sq512;
            min_hold = minute_idx;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (sec_tick || sq512 != sq_hold || minute_idx != min_hold) frozen_ok = 1'b0;
            end
            chk(frozen_ok, "R8 frozen outputs", int'(frozen_ok), 1);
            osc_run = 1'b1;
        end
        drain();

        // full trim cycle at largest negative magnitude, across the wrap
        do_reset(31, 1'b0);
        push_secs(132);
        drain();
        chk(minute_idx == 2, "R3 wrap past minute 63", int'(minute_idx), 2);

        // divider clear
        do_reset(0, 1'b0);
        push_secs(1);
        drain();
        repeat (100) @(negedge clk);
        begin
            logic [MAG_W:0] min_before;
            int cnt = 0;
            mon_on     = 1'b0;
            min_before = minute_idx;
            div_clr    = 1'b1;
            @(negedge clk);
            div_clr    = 1'b0;
            chk(sq512 == 1'b0, "R9 square low after clear", int'(sq512), 0);
            chk(minute_idx == min_before, "R9 minute kept", int'(minute_idx), int'(min_before));
            while (!sec_tick && cnt < 4 * SEC_LEN) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt == SEC_LEN, "R9 first second after clear", cnt, SEC_LEN);
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule